// File: doc/BRIEF.md
# Scanned Input Pin Interrupt Controller

This block raises interrupts from input pins whose values arrive as a periodic serial scan. The shifting logic is outside the block: each completed scan is presented as a one-cycle strobe `smp_valid_i` together with the whole sample vector. The vector holds `NUM_BITS` bit rows of `NUM_PORTS` ports each. The pin at bit row b and port p sits at position `b*NUM_PORTS + p` of `smp_data_i`. For every pin the block applies a programmable trigger kind (level, either edge, falling edge or rising edge), a level polarity and an enable.

Each pin has a sticky pending flag. An event sets it, and software clears it by writing a one to the acknowledge register. Software reads the enabled, pending pins through one identity register per bit row. A single interrupt line is the OR of all identity bits, gated by a master enable.

Software reaches the block through a simple word-addressed port. A write takes one cycle. A read returns its data one cycle after `rd_en_i`. The address is split into a bank (`addr[5:3]`) and a slot (`addr[2:0]`). Register bit p of a row register always refers to port p.

Top module: `scan_pin_irq`

## Requirements
- R1: After reset every readable register returns 0, no pin is pending and `irq_o` is 0.
- R2: A pin's 2-bit trigger code is split across two registers of the trigger bank (bank 1). The low code bit is in slot b (address 0x08+b) and the high code bit is in slot NUM_BITS+b (address 0x0C+b), at register bit p. Code 0 selects level, 1 either edge, 2 falling edge and 3 rising edge.
- R3: With code 3, a strobe whose sample is 1 for a pin whose previous strobed sample was 0 sets that pin's pending flag. No other transition sets it.
- R4: With code 2, only a 1-to-0 change between successive strobed samples sets pending.
- R5: With code 1, any change between successive strobed samples sets pending.
- R6: With code 0, every strobe whose sample equals the active level sets pending. The polarity register sits in bank 0, slot b (address 0x00+b); polarity 0 means high is active and 1 means low is active. A pin that is still active after an acknowledge becomes pending again on the next strobe.
- R7: Writing to bank 3, slot b (address 0x18+b) clears the pending flag of every port whose data bit is 1. Ports whose data bit is 0 are unaffected. If an event for a pin arrives in the same cycle as its acknowledge, the pin stays pending.
- R8: The identity register in bank 4, slot b (address 0x20+b) reads as pending AND enable. The enable register sits in bank 2, slot b (address 0x10+b). A pin with its enable cleared still latches pending, and that pending shows once the pin is enabled.
- R9: `irq_o` is 1 exactly when the master enable (bank 5, slot 0, bit 0; address 0x28) is 1 and some identity bit is 1. It follows the pending state in the cycle after the clock edge that changed it.
- R10: The first strobe after reset produces no edge events, because it has no earlier sample to compare against. Level events do occur on that strobe.
- R11: The polarity, trigger, enable and master registers read back the value last written. The acknowledge bank, unused slots and unused banks read 0, and writes to the identity bank change nothing.
- R12: Without a strobe and without an acknowledge, the pending state does not change, whatever `smp_data_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | One-cycle strobe: a completed scan is on smp_data_i |
| smp_data_i | input | NUM_BITS*NUM_PORTS | Scan sample, pin (b,p) at b*NUM_PORTS+p |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | NUM_PORTS | Write data, bit p = port p |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | NUM_PORTS | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
A strobe or an acknowledge that is present at a rising edge updates the pending flags at that edge. `irq_o` reflects the new state right after that edge, because no register sits between the pending flags and the output. A read samples the register contents as they stand before its edge and presents them right after that edge. The bench therefore computes every read's expected value from its model before it advances the model across the edge. It compares `irq_o` and `rd_data_o` one time unit after each rising edge, against the model state as updated for that same edge.

// File: rtl/scan_pin_irq_pkg.sv
`timescale 1ns/1ps
package scan_pin_irq_pkg;

   // address = {bank, slot}; slot is the bit row (or NUM_BITS+row for trig high)
   localparam int unsigned SLOT_W = 3;
   localparam int unsigned BANK_W = 3;
   localparam int unsigned CFG_MASTER_BIT = 0;

   typedef enum logic [BANK_W-1:0] {
      BANK_POL   = 3'd0,
      BANK_TRIG  = 3'd1,
      BANK_EN    = 3'd2,
      BANK_ACK   = 3'd3,
      BANK_IDENT = 3'd4,
      BANK_CFG   = 3'd5
   } bank_e;

   typedef enum logic [1:0] {
      TRG_LEVEL = 2'd0,
      TRG_BOTH  = 2'd1,
      TRG_FALL  = 2'd2,
      TRG_RISE  = 2'd3
   } trig_e;

endpackage

// File: rtl/scan_pin_irq_regs.sv
`timescale 1ns/1ps
module scan_pin_irq_regs
   import scan_pin_irq_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 32,
   parameter int unsigned NUM_BITS  = 4,
   parameter int unsigned ADDR_W    = 6,
   localparam int unsigned PINS     = NUM_BITS * NUM_PORTS
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [ADDR_W-1:0]    wr_addr_i,
   input  logic [NUM_PORTS-1:0] wr_data_i,
   input  logic                 rd_en_i,
   input  logic [ADDR_W-1:0]    rd_addr_i,
   input  logic [PINS-1:0]      ident_i,
   output logic [NUM_PORTS-1:0] rd_data_o,
   output logic [PINS-1:0]      pol_o,
   output logic [PINS-1:0]      tlo_o,
   output logic [PINS-1:0]      thi_o,
   output logic [PINS-1:0]      en_o,
   output logic [PINS-1:0]      ack_o,
   output logic                 master_o
);

   localparam int unsigned MAP_W = SLOT_W + BANK_W;

   bank_e              wr_bank, rd_bank;
   logic [SLOT_W-1:0]  wr_slot, rd_slot;
   logic               wr_in_map, rd_in_map;
   logic               wr_pol, wr_trig, wr_enb, wr_ack, wr_cfg;
   logic               master_q;
   logic [NUM_PORTS-1:0] rd_next, rd_q;

   assign wr_bank = bank_e'(wr_addr_i[SLOT_W +: BANK_W]);
   assign rd_bank = bank_e'(rd_addr_i[SLOT_W +: BANK_W]);
   assign wr_slot = wr_addr_i[SLOT_W-1:0];
   assign rd_slot = rd_addr_i[SLOT_W-1:0];

   // addresses wider than the map must have zero upper bits to hit
   generate
      if (ADDR_W > MAP_W) begin : g_upper
         assign wr_in_map = ~|wr_addr_i[ADDR_W-1:MAP_W];
         assign rd_in_map = ~|rd_addr_i[ADDR_W-1:MAP_W];
      end else begin : g_exact
         assign wr_in_map = 1'b1;
         assign rd_in_map = 1'b1;
      end
   endgenerate

   assign wr_pol  = wr_en_i & wr_in_map & (wr_bank == BANK_POL);
   assign wr_trig = wr_en_i & wr_in_map & (wr_bank == BANK_TRIG);
   assign wr_enb  = wr_en_i & wr_in_map & (wr_bank == BANK_EN);
   assign wr_ack  = wr_en_i & wr_in_map & (wr_bank == BANK_ACK);
   assign wr_cfg  = wr_en_i & wr_in_map & (wr_bank == BANK_CFG);

   // one register set per bit row
   generate
      for (genvar b = 0; b < NUM_BITS; b++) begin : g_row
         logic [NUM_PORTS-1:0] pol_r, tlo_r, thi_r, en_r;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               pol_r <= '0;
               tlo_r <= '0;
               thi_r <= '0;
               en_r  <= '0;
            end else begin
               if (wr_pol && wr_slot == SLOT_W'(b))
                  pol_r <= wr_data_i;
               if (wr_trig && wr_slot == SLOT_W'(b))
                  tlo_r <= wr_data_i;
               if (wr_trig && wr_slot == SLOT_W'(NUM_BITS + b))
                  thi_r <= wr_data_i;
               if (wr_enb && wr_slot == SLOT_W'(b))
                  en_r <= wr_data_i;
            end
         end

         assign pol_o[b*NUM_PORTS +: NUM_PORTS] = pol_r;
         assign tlo_o[b*NUM_PORTS +: NUM_PORTS] = tlo_r;
         assign thi_o[b*NUM_PORTS +: NUM_PORTS] = thi_r;
         assign en_o [b*NUM_PORTS +: NUM_PORTS] = en_r;
         assign ack_o[b*NUM_PORTS +: NUM_PORTS] =
            (wr_ack && wr_slot == SLOT_W'(b)) ? wr_data_i : '0;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         master_q <= 1'b0;
      else if (wr_cfg && wr_slot == '0)
         master_q <= wr_data_i[CFG_MASTER_BIT];
   end

   assign master_o = master_q;

   always_comb begin
      rd_next = '0;
      if (rd_in_map) begin
         case (rd_bank)
            BANK_POL: begin
               for (int b = 0; b < NUM_BITS; b++)
                  if (rd_slot == SLOT_W'(b))
                     rd_next = pol_o[b*NUM_PORTS +: NUM_PORTS];
            end
            BANK_TRIG: begin
               for (int b = 0; b < NUM_BITS; b++) begin
                  if (rd_slot == SLOT_W'(b))
                     rd_next = tlo_o[b*NUM_PORTS +: NUM_PORTS];
                  if (rd_slot == SLOT_W'(NUM_BITS + b))
                     rd_next = thi_o[b*NUM_PORTS +: NUM_PORTS];
               end
            end
            BANK_EN: begin
               for (int b = 0; b < NUM_BITS; b++)
                  if (rd_slot == SLOT_W'(b))
                     rd_next = en_o[b*NUM_PORTS +: NUM_PORTS];
            end
            BANK_IDENT: begin
               for (int b = 0; b < NUM_BITS; b++)
                  if (rd_slot == SLOT_W'(b))
                     rd_next = ident_i[b*NUM_PORTS +: NUM_PORTS];
            end
            BANK_CFG: begin
               if (rd_slot == '0)
                  rd_next[CFG_MASTER_BIT] = master_q;
            end
            default: rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         rd_q <= '0;
      else if (rd_en_i)
         rd_q <= rd_next;
   end

   assign rd_data_o = rd_q;

endmodule

// File: rtl/scan_pin_irq_detect.sv
`timescale 1ns/1ps
module scan_pin_irq_detect
   import scan_pin_irq_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 32
) (
   input  logic                 valid_i,
   input  logic                 primed_i,
   input  logic [NUM_PORTS-1:0] cur_i,
   input  logic [NUM_PORTS-1:0] prev_i,
   input  logic [NUM_PORTS-1:0] tlo_i,
   input  logic [NUM_PORTS-1:0] thi_i,
   input  logic [NUM_PORTS-1:0] pol_i,
   output logic [NUM_PORTS-1:0] evt_o
);

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin
         trig_e kind;
         logic  rise, fall, active;

         assign kind   = trig_e'({thi_i[p], tlo_i[p]});
         assign rise   = primed_i &  cur_i[p] & ~prev_i[p];
         assign fall   = primed_i & ~cur_i[p] &  prev_i[p];
         assign active = cur_i[p] ^ pol_i[p];

         always_comb begin
            evt_o[p] = 1'b0;
            if (valid_i) begin
               case (kind)
                  TRG_LEVEL: evt_o[p] = active;
                  TRG_BOTH:  evt_o[p] = rise | fall;
                  TRG_FALL:  evt_o[p] = fall;
                  TRG_RISE:  evt_o[p] = rise;
                  default:   evt_o[p] = 1'b0;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/scan_pin_irq_pend.sv
`timescale 1ns/1ps
module scan_pin_irq_pend #(
   parameter int unsigned NUM_PORTS = 32,
   parameter int unsigned NUM_BITS  = 4,
   localparam int unsigned PINS     = NUM_BITS * NUM_PORTS
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            smp_valid_i,
   input  logic [PINS-1:0] smp_data_i,
   input  logic [PINS-1:0] evt_i,
   input  logic [PINS-1:0] ack_i,
   input  logic [PINS-1:0] en_i,
   output logic [PINS-1:0] prev_o,
   output logic            primed_o,
   output logic [PINS-1:0] pend_o,
   output logic [PINS-1:0] ident_o
);

   logic [PINS-1:0] prev_q, pend_q;
   logic            primed_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
         pend_q   <= '0;
      end else begin
         if (smp_valid_i) begin
            prev_q   <= smp_data_i;
            primed_q <= 1'b1;
         end
         // a new event outranks an acknowledge in the same cycle
         pend_q <= (pend_q & ~ack_i) | evt_i;
      end
   end

   assign prev_o   = prev_q;
   assign primed_o = primed_q;
   assign pend_o   = pend_q;
   assign ident_o  = pend_q & en_i;

endmodule

// File: rtl/scan_pin_irq.sv
`timescale 1ns/1ps
module scan_pin_irq #(
   parameter int unsigned NUM_PORTS = 32,
   parameter int unsigned NUM_BITS  = 4,
   parameter int unsigned ADDR_W    = 6
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          smp_valid_i,
   input  logic [NUM_BITS*NUM_PORTS-1:0] smp_data_i,
   input  logic                          wr_en_i,
   input  logic [ADDR_W-1:0]             wr_addr_i,
   input  logic [NUM_PORTS-1:0]          wr_data_i,
   input  logic                          rd_en_i,
   input  logic [ADDR_W-1:0]             rd_addr_i,
   output logic [NUM_PORTS-1:0]          rd_data_o,
   output logic                          irq_o
);

   localparam int unsigned PINS = NUM_BITS * NUM_PORTS;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > 32) begin : g_bad_ports
         $error("scan_pin_irq: NUM_PORTS must be 1..32");
      end
      if (NUM_BITS < 1 || NUM_BITS > 4) begin : g_bad_bits
         $error("scan_pin_irq: NUM_BITS must be 1..4");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("scan_pin_irq: ADDR_W must be at least 6");
      end
   endgenerate

   logic [PINS-1:0] pol, trig_lo, trig_hi, en, ack_mask;
   logic [PINS-1:0] evt, prev, pend, ident;
   logic            primed, master;

   scan_pin_irq_regs #(
      .NUM_PORTS (NUM_PORTS),
      .NUM_BITS  (NUM_BITS),
      .ADDR_W    (ADDR_W)
   ) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (rd_en_i),
      .rd_addr_i (rd_addr_i),
      .ident_i   (ident),
      .rd_data_o (rd_data_o),
      .pol_o     (pol),
      .tlo_o     (trig_lo),
      .thi_o     (trig_hi),
      .en_o      (en),
      .ack_o     (ack_mask),
      .master_o  (master)
   );

   generate
      for (genvar b = 0; b < NUM_BITS; b++) begin : g_det
         scan_pin_irq_detect #(
            .NUM_PORTS (NUM_PORTS)
         ) det_i (
            .valid_i  (smp_valid_i),
            .primed_i (primed),
            .cur_i    (smp_data_i[b*NUM_PORTS +: NUM_PORTS]),
            .prev_i   (prev[b*NUM_PORTS +: NUM_PORTS]),
            .tlo_i    (trig_lo[b*NUM_PORTS +: NUM_PORTS]),
            .thi_i    (trig_hi[b*NUM_PORTS +: NUM_PORTS]),
            .pol_i    (pol[b*NUM_PORTS +: NUM_PORTS]),
            .evt_o    (evt[b*NUM_PORTS +: NUM_PORTS])
         );
      end
   endgenerate

   scan_pin_irq_pend #(
      .NUM_PORTS (NUM_PORTS),
      .NUM_BITS  (NUM_BITS)
   ) pend_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .smp_valid_i (smp_valid_i),
      .smp_data_i  (smp_data_i),
      .evt_i       (evt),
      .ack_i       (ack_mask),
      .en_i        (en),
      .prev_o      (prev),
      .primed_o    (primed),
      .pend_o      (pend),
      .ident_o     (ident)
   );

   assign irq_o = master & (|ident);

endmodule

// File: rtl/scan_pin_irq_chk.sv
`timescale 1ns/1ps
module scan_pin_irq_chk #(
   parameter int unsigned NUM_PORTS = 32,
   parameter int unsigned NUM_BITS  = 4,
   parameter int unsigned ADDR_W    = 6,
   localparam int unsigned PINS     = NUM_BITS * NUM_PORTS
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              smp_valid_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic              cfg_bit_i,
   input logic              irq_i,
   input logic [PINS-1:0]   pend_i,
   input logic [PINS-1:0]   ack_i,
   input logic              primed_i,
   input logic [PINS-1:0]   tmask_i
);

   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(5 * 8);

   // R9: clearing the master enable silences the line on the next cycle
   a_r9_master_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == CFG_ADDR && !cfg_bit_i) |=> !irq_i);

   // R7: acknowledged pins with no competing strobe are clear afterwards
   a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!smp_valid_i && |ack_i) |=> ((pend_i & $past(ack_i)) == '0));

   // R12: no strobe and no acknowledge leaves pending untouched
   a_r12_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!smp_valid_i && ack_i == '0) |=> $stable(pend_i));

   // R10: first strobe after reset raises no edge-mode pin
   a_r10_first_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_valid_i && !primed_i) |=> (((pend_i & ~$past(pend_i)) & $past(tmask_i)) == '0));

endmodule

bind scan_pin_irq scan_pin_irq_chk #(
   .NUM_PORTS (NUM_PORTS),
   .NUM_BITS  (NUM_BITS),
   .ADDR_W    (ADDR_W)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .smp_valid_i (smp_valid_i),
   .wr_en_i     (wr_en_i),
   .wr_addr_i   (wr_addr_i),
   .cfg_bit_i   (wr_data_i[0]),
   .irq_i       (irq_o),
   .pend_i      (pend),
   .ack_i       (ack_mask),
   .primed_i    (primed),
   .tmask_i     (trig_lo | trig_hi)
);

// File: tb/scan_pin_irq_tb.sv
`timescale 1ns/1ps
module scan_pin_irq_tb_top;

   localparam int NP = 32;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          smp_valid = 1'b0;
   logic [NB*NP-1:0] smp_data = '0;
   logic          wr_en = 1'b0;
   logic [5:0]    wr_addr = '0;
   logic [NP-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [5:0]    rd_addr = '0;
   logic [NP-1:0] rd_data;
   logic          irq;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   // model state
   bit [NP-1:0] m_pol[NB], m_tlo[NB], m_thi[NB], m_en[NB], m_pend[NB], m_prev[NB];
   bit m_primed, m_master;
   logic [NB*NP-1:0] cur_vec = '0;

   always #5 clk = ~clk;

   scan_pin_irq dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
   );

   task automatic check(string tag, logic [NP-1:0] got, logic [NP-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic bit [NP-1:0] model_read(bit [5:0] a);
      bit [2:0] bank = a[5:3];
      bit [2:0] slot = a[2:0];
      case (bank)
         3'd0: return (slot < NB) ? m_pol[slot] : '0;
         3'd1: return (slot < NB) ? m_tlo[slot] : (slot < 2*NB) ? m_thi[slot-NB] : '0;
         3'd2: return (slot < NB) ? m_en[slot] : '0;
         3'd4: return (slot < NB) ? (m_pend[slot] & m_en[slot]) : '0;
         3'd5: return (slot == 0) ? NP'(m_master) : '0;
         default: return '0;
      endcase
   endfunction

   function automatic bit pin_event(int b, int p);
      bit cur = smp_data[b*NP+p];
      bit pv = m_prev[b][p];
      case ({m_thi[b][p], m_tlo[b][p]})
         2'd0: return cur ^ m_pol[b][p];
         2'd1: return m_primed && (cur != pv);
         2'd2: return m_primed && pv && !cur;
         default: return m_primed && !pv && cur;
      endcase
   endfunction

   function automatic bit model_irq();
      bit any = 0;
      for (int b = 0; b < NB; b++) any |= |(m_pend[b] & m_en[b]);
      return m_master & any;
   endfunction

   // one clock: inputs already driven; model follows the edge; outputs checked 1 ns later
   task automatic cycle(string tag);
      bit [NP-1:0] exp_rd = '0;
      bit do_rd = rd_en;
      bit [NP-1:0] evt[NB];
      bit [NP-1:0] ack[NB];
      if (do_rd) exp_rd = model_read(rd_addr);
      @(posedge clk);
      for (int b = 0; b < NB; b++) begin
         evt[b] = '0;
         ack[b] = '0;
         if (smp_valid) for (int p = 0; p < NP; p++) evt[b][p] = pin_event(b, p);
         if (wr_en && wr_addr[5:3] == 3'd3 && wr_addr[2:0] == 3'(b)) ack[b] = wr_data;
      end
      for (int b = 0; b < NB; b++) begin
         m_pend[b] = (m_pend[b] & ~ack[b]) | evt[b];
         if (smp_valid) m_prev[b] = smp_data[b*NP +: NP];
      end
      if (smp_valid) m_primed = 1;
      if (wr_en) begin
         case (wr_addr[5:3])
            3'd0: if (wr_addr[2:0] < NB) m_pol[wr_addr[2:0]] = wr_data;
            3'd1: if (wr_addr[2:0] < NB) m_tlo[wr_addr[2:0]] = wr_data;
                  else if (wr_addr[2:0] < 2*NB) m_thi[wr_addr[2:0]-NB] = wr_data;
            3'd2: if (wr_addr[2:0] < NB) m_en[wr_addr[2:0]] = wr_data;
            3'd5: if (wr_addr[2:0] == 0) m_master = wr_data[0];
            default: ;
         endcase
      end
      #1;
      check({tag, " R9 irq"}, NP'(irq), NP'(model_irq()));
      if (do_rd) check({tag, " read"}, rd_data, exp_rd);
      wr_en = 0; rd_en = 0; smp_valid = 0;
   endtask

   task automatic wr(bit [5:0] a, bit [NP-1:0] d, string tag);
      wr_en = 1; wr_addr = a; wr_data = d; cycle(tag);
   endtask

   task automatic rd(bit [5:0] a, string tag);
      rd_en = 1; rd_addr = a; cycle(tag);
   endtask

   task automatic sample(logic [NB*NP-1:0] v, string tag);
      cur_vec = v; smp_data = v; smp_valid = 1; cycle(tag);
   endtask

   task automatic set_pin(bit [NB*NP-1:0] v, int b, int p, bit val, string tag);
      logic [NB*NP-1:0] t = cur_vec;
      t[b*NP+p] = val;
      sample(t, tag);
   endtask

   // R2: splits the code over slot b and slot NB+b
   task automatic set_code(int b, int p, bit [1:0] code);
      bit [NP-1:0] lo = m_tlo[b], hi = m_thi[b];
      lo[p] = code[0]; hi[p] = code[1];
      wr(6'(8 + b), lo, "R2");
      wr(6'(8 + NB + b), hi, "R2");
   endtask

   task automatic set_en(int b, int p, bit v);
      bit [NP-1:0] e = m_en[b];
      e[p] = v;
      wr(6'(16 + b), e, "R8");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h51C0_FFEE));
      for (int b = 0; b < NB; b++) begin
         m_pol[b] = '0; m_tlo[b] = '0; m_thi[b] = '0; m_en[b] = '0; m_pend[b] = '0; m_prev[b] = '0;
      end
      m_primed = 0; m_master = 0;
      repeat (3) @(posedge clk);
      #1 rst_ni = 1;

      // R1: everything reads zero after reset
      for (int a = 0; a < 48; a++) rd(6'(a), "R1");
      check("R1 irq idle", NP'(irq), '0);

      // R10 / R3: rising edge on pin (0,0); first strobe gives no edge
      set_code(0, 0, 2'd3);
      set_en(0, 0, 1);
      wr(6'h28, 1, "R9");
      sample('1, "R10");
      rd(6'h20, "R10 first strobe");
      sample('0, "R3");
      rd(6'h20, "R3 falling ignored");
      set_pin('0, 0, 0, 1, "R3");
      rd(6'h20, "R3 rise sets");
      check("R3 ident bit", rd_data[0], 1'b1);

      // R7: ack with zero data does nothing, ack with one clears
      wr(6'h18, 0, "R7");
      rd(6'h20, "R7 zero ack");
      wr(6'h18, 1, "R7");
      rd(6'h20, "R7 one ack");
      check("R7 cleared", rd_data[0], 1'b0);

      // R4: falling on pin (1,5)
      set_code(1, 5, 2'd2);
      set_en(1, 5, 1);
      set_pin('0, 1, 5, 1, "R4");
      rd(6'h21, "R4 rise ignored");
      set_pin('0, 1, 5, 0, "R4");
      rd(6'h21, "R4 fall sets");

      // R5: both edges on pin (2,31)
      set_code(2, 31, 2'd1);
      set_en(2, 31, 1);
      set_pin('0, 2, 31, 1, "R5");
      rd(6'h22, "R5 rise");
      wr(6'h1A, 32'h8000_0000, "R5");
      set_pin('0, 2, 31, 0, "R5");
      rd(6'h22, "R5 fall");

      // R6: level, active low on pin (3,7)
      wr(6'h03, 32'h80, "R6");
      set_en(3, 7, 1);
      set_pin('0, 3, 7, 0, "R6");
      rd(6'h23, "R6 active");
      wr(6'h1B, 32'h80, "R6");
      rd(6'h23, "R6 acked");
      set_pin('0, 3, 7, 0, "R6");
      rd(6'h23, "R6 reasserts");
      set_pin('0, 3, 7, 1, "R6");
      wr(6'h1B, 32'h80, "R6");
      set_pin('0, 3, 7, 1, "R6");
      rd(6'h23, "R6 inactive stays clear");

      // R7: ack and event in the same cycle, event wins (pin 0,0 rise)
      set_pin('0, 0, 0, 0, "R7");
      wr_en = 1; wr_addr = 6'h18; wr_data = 1;
      cur_vec[0] = 1; smp_data = cur_vec; smp_valid = 1;
      cycle("R7 same cycle");
      rd(6'h20, "R7 event beats ack");

      // R8: pending latches while disabled
      set_en(1, 5, 0);
      wr(6'h19, '1, "R8");
      set_pin('0, 1, 5, 1, "R8");
      set_pin('0, 1, 5, 0, "R8");
      rd(6'h21, "R8 disabled hides");
      set_en(1, 5, 1);
      rd(6'h21, "R8 enable reveals");

      // R9: master gates the line
      wr(6'h28, 0, "R9");
      check("R9 master off", NP'(irq), '0);
      wr(6'h28, 1, "R9");

      // R11: readback, ack bank reads 0, ident write ignored
      rd(6'h0C, "R11 trig high");
      rd(6'h09, "R11 trig low");
      rd(6'h18, "R11 ack reads 0");
      wr(6'h20, '1, "R11");
      rd(6'h20, "R11 ident write ignored");
      rd(6'h3F, "R11 unused");

      // R12: data moves without a strobe
      smp_data = ~cur_vec; cycle("R12");
      smp_data = cur_vec; cycle("R12");
      rd(6'h21, "R12 hold");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op = $urandom % 6;
         case (op)
            0: wr(6'($urandom % 3 * 8 + $urandom % 8), $urandom, "R2 rnd cfg");
            1: wr(6'h28, NP'($urandom % 4 != 0), "R9 rnd master");
            2, 3: begin
               logic [NB*NP-1:0] t = cur_vec;
               for (int k = 0; k < 3; k++) t[$urandom % (NB*NP)] ^= 1'b1;
               sample(t, "R5 rnd sample");
            end
            4: wr(6'(24 + $urandom % NB), $urandom, "R7 rnd ack");
            default: begin
               smp_data = cur_vec ^ NB*NP'($urandom);
               rd(6'(32 + $urandom % NB), "R8 rnd ident");
               smp_data = cur_vec;
            end
         endcase
      end
      for (int b = 0; b < NB; b++) rd(6'(32 + b), "R8 final ident");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule